// File: doc/BRIEF.md
# Round-Robin Single-Buffer DMA Engine

This block is a memory-to-memory copy engine with a small set of channels that share one word-wide memory port. Each channel holds a source address, a destination address, a byte count, a run flag and a forced-failure countdown. Software programs these through a register write port. It then sets the run flag and waits for the channel's completion or error flag, which raises a single interrupt line.

Work is paced by a tick strobe. Each accepted tick visits exactly one channel, chosen by a rotating pointer. A running channel with bytes left copies one burst, capped at a fixed size, one 32-bit word per clock. A running channel whose count is already zero finishes on that visit. A channel whose failure countdown runs out stops with an error and copies nothing. Addresses are expected to be multiples of 4. A count that is not a multiple of 4 ends with a partial word written under byte enables.

Top module: `rr_dma_engine`

## Requirements
- R1: Each tick accepted while no burst is in progress visits exactly one channel and advances the pointer by one. The pointer starts at channel 0 after reset and wraps from the last channel back to channel 0.
- R2: A visited channel whose run flag is clear is left untouched and produces no memory traffic, but the pointer still advances.
- R3: A visit to a running channel with a nonzero count copies min(count, 2048) bytes, one word per clock starting the clock after the tick, reading at the source and writing the read data at the destination. The source and destination addresses each grow, and the count shrinks, by the number of bytes moved.
- R4: A visit to a running channel whose count is already zero clears its run flag and sets its completion flag (bit c of done_flags for channel c). Completion is therefore signalled one visit after the last burst.
- R5: On each visit to a running channel, a nonzero fail countdown is decremented. If that makes it zero, the visit clears the run flag, sets bit c of err_flags, and copies nothing; otherwise the visit proceeds as in R3 or R4.
- R6: A word that carries fewer than 4 remaining bytes of a burst is written with mem_wr_be covering only the low-order bytes (1 byte: 0001, 2 bytes: 0011, 3 bytes: 0111). A full word uses 1111.
- R7: Writing the control register with bit 31 clear stops a channel by clearing only its run flag; its addresses and count are kept, and setting bit 31 again resumes from them. ch_busy bit c equals channel c's run flag, so a clear bit means idle.
- R8: Writing the completion or error flag register clears the flags whose bits are 1 and leaves the rest. A flag set by the engine in the same cycle stays set. irq is high while any completion or error flag is set.
- R9: A tick that arrives while a burst is in progress is ignored: the pointer does not move and no extra visit happens.
- R10: reg_addr[4:3] selects the channel and reg_addr[2:0] the field: 0 source, 1 destination, 2 count (13 bits, up to 0x1FFF), 3 control (bit 31 = run), 4 fail countdown (8 bits), 5 completion flags write-1-to-clear, 6 error flags write-1-to-clear. For fields 5 and 6 the channel bits are ignored. Reset clears every register and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Service strobe; one channel visit per accepted tick |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Channel (bits 4:3) and field (bits 2:0) |
| reg_wdata | input | 32 | Register write data |
| mem_rd_en | output | 1 | Memory read request, one word per clock during a burst |
| mem_rd_addr | output | 32 | Byte address of the word being read |
| mem_rd_data | input | 32 | Read data, valid in the same cycle as the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 32 | Byte address of the word being written |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Byte enables, bit 0 for the lowest byte |
| ch_busy | output | 4 | Run flag per channel |
| done_flags | output | 4 | Completion flag per channel |
| err_flags | output | 4 | Error flag per channel |
| irq | output | 1 | OR of all completion and error flags |

## Verification
The bench builds the engine with its default parameters: four channels, a 2048-byte burst cap, a 13-bit count and an 8-bit fail countdown. With these values a 0x1003-byte transfer takes two capped bursts and a 3-byte tail, a 4096-byte transfer can be stopped between its two bursts and resumed, and the pointer wraps several times across a mix of idle, completing, failing and copying channels. A per-cycle reference model predicts every write address, data word, byte-enable pattern and flag, and covers ticks issued in the middle of a burst.

// File: rtl/rr_dma_engine.sv
module rr_dma_engine #(
  parameter int NUM_CH      = 4,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 13,
  parameter int BURST_BYTES = 2048,
  parameter int FAIL_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_we,
  input  logic [$clog2(NUM_CH)+2:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic [3:0]        mem_wr_be,
  output logic [NUM_CH-1:0] ch_busy,
  output logic [NUM_CH-1:0] done_flags,
  output logic [NUM_CH-1:0] err_flags,
  output logic              irq
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int BL_W = $clog2(BURST_BYTES) + 1;

  logic [ADDR_W-1:0] src_q [NUM_CH];
  logic [ADDR_W-1:0] dst_q [NUM_CH];
  logic [CNT_W-1:0]  cnt_q [NUM_CH];
  logic [FAIL_W-1:0] fail_q [NUM_CH];
  logic [NUM_CH-1:0] run_q, done_q, err_q;
  logic [CH_W-1:0]   ptr, cur;
  logic [BL_W-1:0]   blen;
  logic              copying;

  logic [CH_W-1:0] wch;
  logic [2:0]      wfld, step;
  logic            fail_hit;
  logic [BL_W-1:0] first_len;

  assign wch  = reg_addr[CH_W+2:3];
  assign wfld = reg_addr[2:0];
  assign step = (blen >= BL_W'(4)) ? 3'd4 : blen[2:0];
  assign fail_hit  = (fail_q[ptr] == FAIL_W'(1));
  assign first_len = (cnt_q[ptr] > CNT_W'(BURST_BYTES)) ? BL_W'(BURST_BYTES) : BL_W'(cnt_q[ptr]);

  assign mem_rd_en   = copying;
  assign mem_wr_en   = copying;
  assign mem_rd_addr = src_q[cur];
  assign mem_wr_addr = dst_q[cur];
  assign mem_wr_data = mem_rd_data;
  assign mem_wr_be   = (blen >= BL_W'(4)) ? 4'hF : ((4'h1 << blen[1:0]) - 4'h1);
  assign ch_busy     = run_q;
  assign done_flags  = done_q;
  assign err_flags   = err_q;
  assign irq         = |{done_q, err_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        cnt_q[i]  <= '0;
        fail_q[i] <= '0;
      end
      run_q   <= '0;
      done_q  <= '0;
      err_q   <= '0;
      ptr     <= '0;
      cur     <= '0;
      blen    <= '0;
      copying <= 1'b0;
    end else begin
      if (reg_we) begin
        case (wfld)
          3'd0: src_q[wch]  <= ADDR_W'(reg_wdata);
          3'd1: dst_q[wch]  <= ADDR_W'(reg_wdata);
          3'd2: cnt_q[wch]  <= reg_wdata[CNT_W-1:0];
          3'd3: run_q[wch]  <= reg_wdata[31];
          3'd4: fail_q[wch] <= reg_wdata[FAIL_W-1:0];
          3'd5: done_q <= done_q & ~reg_wdata[NUM_CH-1:0];
          3'd6: err_q  <= err_q & ~reg_wdata[NUM_CH-1:0];
          default: ;
        endcase
      end
      if (copying) begin
        src_q[cur] <= src_q[cur] + ADDR_W'(step);
        dst_q[cur] <= dst_q[cur] + ADDR_W'(step);
        cnt_q[cur] <= cnt_q[cur] - CNT_W'(step);
        blen       <= blen - BL_W'(step);
        if (blen <= BL_W'(4)) copying <= 1'b0;
      end else if (tick) begin
        ptr <= (ptr == CH_W'(NUM_CH - 1)) ? '0 : ptr + CH_W'(1);
        if (run_q[ptr]) begin
          if (fail_q[ptr] != '0) fail_q[ptr] <= fail_q[ptr] - FAIL_W'(1);
          if (fail_hit) begin
            run_q[ptr] <= 1'b0;
            err_q[ptr] <= 1'b1;
          end else if (cnt_q[ptr] == '0) begin
            run_q[ptr]  <= 1'b0;
            done_q[ptr] <= 1'b1;
          end else begin
            copying <= 1'b1;
            cur     <= ptr;
            blen    <= first_len;
          end
        end
      end
    end
  end

  assert_ptr_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !copying && ptr == CH_W'(NUM_CH - 1)) |=> (ptr == '0));

  assert_tick_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && copying) |=> $stable(ptr));

  assert_be_low_bytes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_wr_be inside {4'h1, 4'h3, 4'h7, 4'hF}));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag_chk
    assert_done_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q[g]) |-> !run_q[g]);
    assert_err_no_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q[g]) |-> (!run_q[g] && !copying));
  end
endmodule

// File: tb/rr_dma_engine_test.sv
module rr_dma_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_rd_en, mem_wr_en, irq;
  logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
  logic [3:0]  mem_wr_be, ch_busy, done_flags, err_flags;

  always #5 clk = ~clk;

  function automatic logic [31:0] pattern(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
  endfunction

  assign mem_rd_data = pattern(mem_rd_addr);

  rr_dma_engine uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be), .ch_busy(ch_busy),
    .done_flags(done_flags), .err_flags(err_flags), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  logic [31:0] m_src [4];
  logic [31:0] m_dst [4];
  int          m_cnt [4];
  int          m_fail [4];
  logic [3:0]  m_run, m_done, m_err;
  int          m_ptr, m_ch, m_left;
  bit          m_busy;

  function automatic int min4(input int v);
    return (v >= 4) ? 4 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0; m_fail[i] = 0;
      end
      m_run = 0; m_done = 0; m_err = 0; m_ptr = 0; m_ch = 0; m_left = 0; m_busy = 0;
    end else begin
      if (reg_we) begin
        int c;
        c = reg_addr[4:3];
        case (reg_addr[2:0])
          3'd0: m_src[c] = reg_wdata;
          3'd1: m_dst[c] = reg_wdata;
          3'd2: m_cnt[c] = reg_wdata & 32'h1FFF;
          3'd3: m_run[c] = reg_wdata[31];
          3'd4: m_fail[c] = reg_wdata & 32'hFF;
          3'd5: m_done = m_done & ~reg_wdata[3:0];
          3'd6: m_err = m_err & ~reg_wdata[3:0];
          default: ;
        endcase
      end
      if (m_busy) begin
        int s;
        s = min4(m_left);
        m_src[m_ch] += s; m_dst[m_ch] += s; m_cnt[m_ch] -= s; m_left -= s;
        if (m_left == 0) m_busy = 0;
      end else if (tick) begin
        int c;
        bit failed;
        c = m_ptr;
        m_ptr = (m_ptr + 1) % 4;
        if (m_run[c]) begin
          failed = 0;
          if (m_fail[c] > 0) begin
            m_fail[c]--;
            failed = (m_fail[c] == 0);
          end
          if (failed) begin
            m_run[c] = 0; m_err[c] = 1;
          end else if (m_cnt[c] == 0) begin
            m_run[c] = 0; m_done[c] = 1;
          end else begin
            m_busy = 1; m_ch = c;
            m_left = (m_cnt[c] > 2048) ? 2048 : m_cnt[c];
          end
        end
      end
    end
  end

  // compare outputs against the model every cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 run/idle", {28'd0, ch_busy}, {28'd0, m_run});
      chk("R4 completion flags", {28'd0, done_flags}, {28'd0, m_done});
      chk("R5 error flags", {28'd0, err_flags}, {28'd0, m_err});
      chk("R8 irq", {31'd0, irq}, {31'd0, |{m_done, m_err}});
      chk("R2 R9 write strobe", {31'd0, mem_wr_en}, {31'd0, m_busy});
      if (m_busy) begin
        int s;
        s = min4(m_left);
        chk("R1 R3 write address", mem_wr_addr, m_dst[m_ch]);
        chk("R3 read address", mem_rd_addr, m_src[m_ch]);
        chk("R3 R10 write data", mem_wr_data, pattern(m_src[m_ch]));
        chk("R6 byte enables", {28'd0, mem_wr_be}, (s == 4) ? 32'hF : ((32'd1 << s) - 1));
      end
    end
  end

  task automatic wr(input int ch, input int fld, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {ch[1:0], fld[2:0]}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                      input int cnt, input int fl);
    wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, cnt); wr(ch, 4, fl); wr(ch, 3, 32'h8000_0000);
  endtask

  task automatic do_tick(input bit extra_mid_burst);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (extra_mid_burst && m_busy) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset flags", {20'd0, ch_busy, done_flags, err_flags}, 32'd0);
    chk("R10 reset irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", {31'd0, mem_wr_en}, 32'd0);

    prog(0, 32'h0000_1000, 32'h0000_8000, 32'h1003, 0);
    prog(2, 32'h0000_3000, 32'h0000_9000, 8, 2);
    prog(3, 32'h0000_5000, 32'h0000_B000, 0, 0);
    chk("R7 busy after start", {28'd0, ch_busy}, 32'hD);

    do_tick(1'b1);                // ch0 burst, extra tick ignored (R9)
    do_tick(1'b0);                // ch1 idle, skipped (R2)
    do_tick(1'b0);                // ch2 copies, countdown 2 -> 1
    do_tick(1'b0);                // ch3 count zero -> done
    chk("R4 done after zero-count visit", {28'd0, done_flags}, 32'h8);
    chk("R2 R9 visit order kept", {28'd0, ch_busy}, 32'h5);
    repeat (8) do_tick(1'b0);     // ch0 second burst and 3-byte tail, ch2 fails
    chk("R5 error flag", {28'd0, err_flags}, 32'h4);
    chk("R4 completion waits one more visit", {28'd0, ch_busy}, 32'h1);
    do_tick(1'b0);                // ch0 count zero -> done, pointer wraps (R1)
    chk("R1 R4 done flags", {28'd0, done_flags}, 32'h9);
    chk("R7 all idle", {28'd0, ch_busy}, 32'h0);

    wr(0, 5, 32'h1);
    chk("R8 partial clear", {28'd0, done_flags}, 32'h8);
    chk("R8 irq held", {31'd0, irq}, 32'h1);
    wr(2, 5, 32'h8); wr(1, 6, 32'h4);
    chk("R8 irq low after clear", {31'd0, irq}, 32'h0);

    prog(1, 32'h0000_4000, 32'h0000_A000, 32'h1000, 0);
    do_tick(1'b0);                // ch1 first burst
    wr(1, 3, 32'h0);              // stop
    chk("R7 stop clears run", {28'd0, ch_busy}, 32'h0);
    repeat (4) do_tick(1'b0);
    chk("R7 stopped channel silent", {28'd0, done_flags}, 32'h0);
    wr(1, 3, 32'h8000_0000);      // resume from retained state
    repeat (4) do_tick(1'b0);
    repeat (4) do_tick(1'b0);
    chk("R7 resumed channel completes", {28'd0, done_flags}, 32'h2);

    prog(3, 32'h0000_6000, 32'h0000_C000, 4, 1);
    repeat (4) do_tick(1'b0);
    chk("R5 immediate failure", {28'd0, err_flags}, 32'h8);
    chk("R5 no completion on failure", {28'd0, done_flags}, 32'h2);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual 100000 cycles expected completion earlier");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule